// File: doc/BRIEF.md
# Frequency Sweep Measurement Sequencer

This block is the control core of a stepped-frequency impedance measurement engine. A host writes and reads it one byte at a time through a byte-addressed register file. The file holds the configuration, a start frequency code, a step code, a step count and a settling count. It also holds a status byte and the captured temperature, real and imaginary results. Writing the control high byte passes the command in its upper nibble to a sequencer. The sequencer starts the excitation at the start code, and a sweep then takes one measurement per frequency point. Each step moves the 24-bit frequency code on by the step code. A point can be measured again, and a temperature measurement can be run between points. The sequencer can also go to standby or power down.

The analog front end and the transform datapath sit outside. They see the current frequency code, an excitation-enable level and a measurement request, which also says whether it is an impedance or a temperature measurement. They return the results on a one-cycle completion strobe. Before each impedance measurement the block waits out a programmable settling time, counted in clock cycles.

Top module: `sweep_seq_top`

## Requirements
- R1: After the synchronous active-low reset: every status flag is 0, the frequency code is 0, and both excitation and measurement request are low. Every register reads 0.
- R2: Multi-byte registers are big-endian, with the most significant byte at the lowest address. The start code is 24 bits at 0x82..0x84, the step code 24 bits at 0x85..0x87, the step count 9 bits at 0x88..0x89 and the settling count 11 bits at 0x8A..0x8B. Bits above each register's width read as 0.
- R3: Command 0x1 in bits 7:4 of address 0x80 is accepted in any state. It loads the frequency code from the start code and turns the excitation on. It raises no measurement request.
- R4: Command 0x2 (sweep) is accepted only while the excitation has been initialised by 0x1 and nothing is being measured, and is ignored in any other state. It reloads the start code, clears the step counter and clears the data-valid and sweep-done flags. It then begins a settle-and-measure cycle with the request kind low (impedance).
- R5: The settling count holds a base value in bits 8:0 and a multiplier code in bits 10:9 (01 = ×2, 11 = ×4, otherwise ×1). The measurement request rises N+1 cycles after the clock edge that takes the command, where N = base × multiplier.
- R6: When the completion strobe arrives while an impedance request is high, the request drops. The real and imaginary results are stored at 0x94..0x95 and 0x96..0x97, and status bit 1 (data valid) sets.
- R7: Command 0x3 (step), when a result is held and the sweep is not done, adds the step code to the frequency code modulo 2^24. It increments the step counter, clears data valid and starts a new measurement. After sweep done it is ignored.
- R8: Status bit 2 (sweep done) sets on the completion of a measurement taken when the step counter equals the programmed step count, and not before.
- R9: Command 0x4 (repeat), when a result is held, clears data valid and measures again at an unchanged frequency code.
- R10: Command 0x9 (temperature), accepted only while no measurement or settling is in progress, clears status bit 0 and raises the request with the kind high. On completion the temperature result is stored at 0x92..0x93, status bit 0 sets and the sequencer returns to the state it came from.
- R11: Command 0xA (power down) clears all status flags, drops the excitation and aborts any measurement. Command 0xB (standby) drops the excitation and aborts any measurement, and keeps the flags.
- R12: Writing 1 to bit 4 of address 0x81 returns the sequencer to standby, drops the excitation and clears the status flags. The programmed registers are left unchanged, and bit 4 reads back as 0 while bit 3 is stored.
- R13: Bits 3:0 of each write to 0x80 are stored and read back, with bits 7:4 reading 0. A command code that is not listed above (such as 0x0) changes nothing in the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte (combinational) |
| meas_done | input | 1 | One-cycle measurement completion strobe |
| meas_real | input | 16 | Real result, valid with meas_done |
| meas_imag | input | 16 | Imaginary result, valid with meas_done |
| meas_temp | input | 16 | Temperature result, valid with meas_done |
| meas_req | output | 1 | Measurement request |
| meas_kind | output | 1 | 1 = temperature request, 0 = impedance |
| excite_on | output | 1 | Excitation enable |
| freq_code | output | 24 | Current frequency code |

## Verification
The bench builds the block with the default widths: a 24-bit frequency code, a 9-bit step count and an 11-bit settling count. With these widths a start code close to 2^24 makes the frequency code wrap on a step. A step count of 511 keeps the done flag low through the full 9-bit range before it sets. Both settling multipliers can be timed against the request edge in a few dozen cycles.

// File: rtl/sweep_pkg.sv
// Shared types and constants of the sweep sequencer.
// Assumes a byte-wide host port with a fixed address map.
package sweep_pkg;

    localparam int DATA_W = 16;

    localparam logic [7:0] A_CTRL_HI = 8'h80;
    localparam logic [7:0] A_CTRL_LO = 8'h81;
    localparam logic [7:0] A_START   = 8'h82;
    localparam logic [7:0] A_STEP    = 8'h85;
    localparam logic [7:0] A_COUNT   = 8'h88;
    localparam logic [7:0] A_SETTLE  = 8'h8A;
    localparam logic [7:0] A_STATUS  = 8'h8F;
    localparam logic [7:0] A_TEMP    = 8'h92;
    localparam logic [7:0] A_REAL    = 8'h94;
    localparam logic [7:0] A_IMAG    = 8'h96;

    typedef enum logic [3:0] {
        C_INIT  = 4'h1,
        C_SWEEP = 4'h2,
        C_STEP  = 4'h3,
        C_AGAIN = 4'h4,
        C_TEMP  = 4'h9,
        C_OFF   = 4'hA,
        C_STBY  = 4'hB
    } seq_cmd_e;

    typedef enum logic [2:0] {
        S_STBY,
        S_INIT,
        S_SETTLE,
        S_MEAS,
        S_HOLD,
        S_TEMP,
        S_OFF
    } seq_state_e;

endpackage

// File: rtl/sweep_regs.sv
// Host register file: byte writes into big-endian fields, command and
// soft-reset decode, combinational read mux.
// Assumes FREQ_W is a multiple of 8, CNT_W <= 16, SET_W in 10..16.
module sweep_regs
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int CNT_W  = 9,
    parameter int SET_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic [2:0]        status,
    input  logic [DATA_W-1:0] res_temp,
    input  logic [DATA_W-1:0] res_real,
    input  logic [DATA_W-1:0] res_imag,
    output logic [FREQ_W-1:0] start_code,
    output logic [FREQ_W-1:0] step_code,
    output logic [CNT_W-1:0]  num_steps,
    output logic [SET_W-1:0]  settle_raw,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic              soft_rst
);
    localparam int FB = FREQ_W / 8;

    logic [FREQ_W-1:0] start_q, step_q;
    logic [CNT_W-1:0]  count_q;
    logic [SET_W-1:0]  settle_q;
    logic [3:0]        cfg_q;
    logic              extclk_q;
    logic [15:0]       count_w, settle_w;

    assign count_w  = {{(16-CNT_W){1'b0}}, count_q};
    assign settle_w = {{(16-SET_W){1'b0}}, settle_q};

    // Write path: one byte per strobe into the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            step_q   <= '0;
            count_q  <= '0;
            settle_q <= '0;
            cfg_q    <= '0;
            extclk_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < FB; i++) begin
                if (wr_addr == A_START + 8'(i))
                    start_q[(FB-1-i)*8 +: 8] <= wr_data;
                if (wr_addr == A_STEP + 8'(i))
                    step_q[(FB-1-i)*8 +: 8] <= wr_data;
            end
            if (wr_addr == A_COUNT)
                count_q <= CNT_W'({wr_data, count_w[7:0]});
            if (wr_addr == A_COUNT + 8'd1)
                count_q <= CNT_W'({count_w[15:8], wr_data});
            if (wr_addr == A_SETTLE)
                settle_q <= SET_W'({wr_data, settle_w[7:0]});
            if (wr_addr == A_SETTLE + 8'd1)
                settle_q <= SET_W'({settle_w[15:8], wr_data});
            if (wr_addr == A_CTRL_HI)
                cfg_q <= wr_data[3:0];
            if (wr_addr == A_CTRL_LO)
                extclk_q <= wr_data[3];
        end
    end

    // Command and soft-reset strobes decoded straight from the write.
    always_comb begin
        cmd_valid = wr_en && (wr_addr == A_CTRL_HI);
        cmd_code  = wr_data[7:4];
        soft_rst  = wr_en && (wr_addr == A_CTRL_LO) && wr_data[4];
    end

    // Read mux over all mapped bytes; unmapped bytes read 0.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < FB; i++) begin
            if (rd_addr == A_START + 8'(i)) rd_data = start_q[(FB-1-i)*8 +: 8];
            if (rd_addr == A_STEP + 8'(i))  rd_data = step_q[(FB-1-i)*8 +: 8];
        end
        case (rd_addr)
            A_CTRL_HI:        rd_data = {4'h0, cfg_q};
            A_CTRL_LO:        rd_data = {4'h0, extclk_q, 3'b000};
            A_COUNT:          rd_data = count_w[15:8];
            A_COUNT + 8'd1:   rd_data = count_w[7:0];
            A_SETTLE:         rd_data = settle_w[15:8];
            A_SETTLE + 8'd1:  rd_data = settle_w[7:0];
            A_STATUS:         rd_data = {5'b0, status};
            A_TEMP:           rd_data = res_temp[15:8];
            A_TEMP + 8'd1:    rd_data = res_temp[7:0];
            A_REAL:           rd_data = res_real[15:8];
            A_REAL + 8'd1:    rd_data = res_real[7:0];
            A_IMAG:           rd_data = res_imag[15:8];
            A_IMAG + 8'd1:    rd_data = res_imag[7:0];
            default:          ;
        endcase
    end

    assign start_code = start_q;
    assign step_code  = step_q;
    assign num_steps  = count_q;
    assign settle_raw = settle_q;

endmodule

// File: rtl/sweep_settle.sv
// Settling timer: loads base x multiplier and counts down to zero.
// Assumes the multiplier code sits in the top two bits of settle_raw.
module sweep_settle #(
    parameter int SET_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SET_W-1:0] settle_raw,
    output logic             expired
);
    localparam int BASE_W = SET_W - 2;

    logic [SET_W-1:0] eff, cnt_q;

    // Effective count: base shifted by the multiplier code.
    always_comb begin
        case (settle_raw[SET_W-1 -: 2])
            2'b01:   eff = {1'b0, settle_raw[BASE_W-1:0], 1'b0};
            2'b11:   eff = {settle_raw[BASE_W-1:0], 2'b00};
            default: eff = {2'b00, settle_raw[BASE_W-1:0]};
        endcase
    end

    // Down counter, reloaded on each new settle-and-measure cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= eff;
        else if (run && cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sweep_fsm.sv
// Sweep sequencer: accepts commands, steps the frequency code, hands
// measurement requests out and captures results and status flags.
// Assumes at most one command per cycle; a command wins over completion.
module sweep_fsm
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic              soft_rst,
    input  logic [FREQ_W-1:0] start_code,
    input  logic [FREQ_W-1:0] step_code,
    input  logic [CNT_W-1:0]  num_steps,
    input  logic              settle_done,
    input  logic              meas_done,
    input  logic [DATA_W-1:0] meas_real,
    input  logic [DATA_W-1:0] meas_imag,
    input  logic [DATA_W-1:0] meas_temp,
    output seq_state_e        state,
    output logic              settle_load,
    output logic [FREQ_W-1:0] freq_code,
    output logic              excite_on,
    output logic [2:0]        status,
    output logic [DATA_W-1:0] res_temp,
    output logic [DATA_W-1:0] res_real,
    output logic [DATA_W-1:0] res_imag
);
    seq_state_e        st_q, ret_q;
    logic [FREQ_W-1:0] code_q;
    logic [CNT_W-1:0]  steps_q;
    logic              tv_q, dv_q, done_q, exc_q;
    logic              acc_init, acc_sweep, acc_step, acc_again;
    logic              acc_temp, acc_off, acc_stby, idle_st;

    // Command acceptance by current state.
    always_comb begin
        idle_st   = (st_q == S_STBY) || (st_q == S_INIT) ||
                    (st_q == S_HOLD) || (st_q == S_OFF);
        acc_init  = cmd_valid && cmd_code == C_INIT;
        acc_sweep = cmd_valid && cmd_code == C_SWEEP && st_q == S_INIT;
        acc_step  = cmd_valid && cmd_code == C_STEP && st_q == S_HOLD && !done_q;
        acc_again = cmd_valid && cmd_code == C_AGAIN && st_q == S_HOLD;
        acc_temp  = cmd_valid && cmd_code == C_TEMP && idle_st;
        acc_off   = cmd_valid && cmd_code == C_OFF;
        acc_stby  = cmd_valid && cmd_code == C_STBY;
        settle_load = !soft_rst && (acc_sweep || acc_step || acc_again);
    end

    // Sequencer state, frequency stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_STBY;
            ret_q    <= S_STBY;
            code_q   <= '0;
            steps_q  <= '0;
            tv_q     <= 1'b0;
            dv_q     <= 1'b0;
            done_q   <= 1'b0;
            exc_q    <= 1'b0;
            res_temp <= '0;
            res_real <= '0;
            res_imag <= '0;
        end else if (soft_rst) begin
            st_q   <= S_STBY;
            exc_q  <= 1'b0;
            tv_q   <= 1'b0;
            dv_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (acc_off) begin
            st_q   <= S_OFF;
            exc_q  <= 1'b0;
            tv_q   <= 1'b0;
            dv_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (acc_stby) begin
            st_q  <= S_STBY;
            exc_q <= 1'b0;
        end else if (acc_init) begin
            st_q    <= S_INIT;
            code_q  <= start_code;
            steps_q <= '0;
            exc_q   <= 1'b1;
        end else if (acc_sweep) begin
            st_q    <= S_SETTLE;
            code_q  <= start_code;
            steps_q <= '0;
            dv_q    <= 1'b0;
            done_q  <= 1'b0;
        end else if (acc_step) begin
            st_q    <= S_SETTLE;
            code_q  <= code_q + step_code;
            steps_q <= steps_q + 1'b1;
            dv_q    <= 1'b0;
        end else if (acc_again) begin
            st_q <= S_SETTLE;
            dv_q <= 1'b0;
        end else if (acc_temp) begin
            ret_q <= st_q;
            st_q  <= S_TEMP;
            tv_q  <= 1'b0;
        end else begin
            case (st_q)
                S_SETTLE: if (settle_done) st_q <= S_MEAS;
                S_MEAS: if (meas_done) begin
                    res_real <= meas_real;
                    res_imag <= meas_imag;
                    dv_q     <= 1'b1;
                    if (steps_q == num_steps) done_q <= 1'b1;
                    st_q     <= S_HOLD;
                end
                S_TEMP: if (meas_done) begin
                    res_temp <= meas_temp;
                    tv_q     <= 1'b1;
                    st_q     <= ret_q;
                end
                default: ;
            endcase
        end
    end

    assign state     = st_q;
    assign freq_code = code_q;
    assign excite_on = exc_q;
    assign status    = {done_q, dv_q, tv_q};

endmodule

// File: rtl/sweep_seq_top.sv
// Top of the sweep sequencer: register file, settling timer and
// sequencer joined; request outputs decoded from the sequencer state.
// Assumes the front end holds results stable while meas_done is high.
module sweep_seq_top
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int CNT_W  = 9,
    parameter int SET_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              meas_done,
    input  logic [15:0]       meas_real,
    input  logic [15:0]       meas_imag,
    input  logic [15:0]       meas_temp,
    output logic              meas_req,
    output logic              meas_kind,
    output logic              excite_on,
    output logic [FREQ_W-1:0] freq_code
);
    logic [FREQ_W-1:0] start_w, step_w;
    logic [CNT_W-1:0]  count_w;
    logic [SET_W-1:0]  settle_w;
    logic              cmd_v, soft_w, load_w, expired_w;
    logic [3:0]        cmd_c;
    logic [2:0]        stat_w;
    logic [DATA_W-1:0] temp_w, real_w, imag_w;
    seq_state_e        state_w;

    sweep_regs #(.FREQ_W(FREQ_W), .CNT_W(CNT_W), .SET_W(SET_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .status(stat_w), .res_temp(temp_w), .res_real(real_w),
        .res_imag(imag_w), .start_code(start_w), .step_code(step_w),
        .num_steps(count_w), .settle_raw(settle_w), .cmd_valid(cmd_v),
        .cmd_code(cmd_c), .soft_rst(soft_w)
    );

    sweep_settle #(.SET_W(SET_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(load_w),
        .run(state_w == S_SETTLE), .settle_raw(settle_w),
        .expired(expired_w)
    );

    sweep_fsm #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_v), .cmd_code(cmd_c),
        .soft_rst(soft_w), .start_code(start_w), .step_code(step_w),
        .num_steps(count_w), .settle_done(expired_w),
        .meas_done(meas_done), .meas_real(meas_real),
        .meas_imag(meas_imag), .meas_temp(meas_temp), .state(state_w),
        .settle_load(load_w), .freq_code(freq_code), .excite_on(excite_on),
        .status(stat_w), .res_temp(temp_w), .res_real(real_w),
        .res_imag(imag_w)
    );

    // Request outputs follow the sequencer state.
    always_comb begin
        meas_req  = (state_w == S_MEAS) || (state_w == S_TEMP);
        meas_kind = (state_w == S_TEMP);
    end

endmodule

// File: rtl/sweep_checker.sv
// Checker for the sweep sequencer, bound to the top module.
// Assumes the bound signals are the top's internal register outputs.
module sweep_checker #(
    parameter int FREQ_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              meas_req,
    input logic              meas_done,
    input logic              excite_on,
    input logic [FREQ_W-1:0] freq_code,
    input logic [2:0]        status,
    input logic [FREQ_W-1:0] start_code,
    input logic [FREQ_W-1:0] step_code,
    input logic              in_hold
);
    logic cmd_w;
    assign cmd_w = wr_en && wr_addr == 8'h80;

    // R3: initialise loads the start code with excitation and no request
    a_r3_init_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wr_data[7:4] == 4'h1) |=>
        (!meas_req && excite_on && freq_code == $past(start_code)));

    // R7: an accepted step adds the step code modulo the code width
    a_r7_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wr_data[7:4] == 4'h3 && in_hold && !status[2]) |=>
        (freq_code == FREQ_W'($past(freq_code) + $past(step_code))));

    // R6: completion with no concurrent write drops the request
    a_r6_done_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && meas_done && !wr_en) |=> !meas_req);

    // R8: sweep done only rises together with data valid
    a_r8_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> status[1]);

    // R11: power down clears flags, excitation and request
    a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wr_data[7:4] == 4'hA) |=>
        (status == 3'b000 && !excite_on && !meas_req));

    // R12: soft reset clears flags and stops the sequencer
    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h81 && wr_data[4]) |=>
        (status == 3'b000 && !excite_on && !meas_req));

endmodule

bind sweep_seq_top sweep_checker #(.FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .meas_req(meas_req), .meas_done(meas_done),
    .excite_on(excite_on), .freq_code(freq_code), .status(stat_w),
    .start_code(start_w), .step_code(step_w),
    .in_hold(state_w == sweep_pkg::S_HOLD)
);

// File: tb/test_sweep_seq_top.sv
// Directed bench for the sweep sequencer: one task per scenario.
module test_sweep_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIM   = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0]  rd_data;
    logic        meas_done = 1'b0;
    logic [15:0] meas_real = '0, meas_imag = '0, meas_temp = '0;
    logic        meas_req, meas_kind, excite_on;
    logic [23:0] freq_code;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    sweep_seq_top i_sweep_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .meas_done(meas_done), .meas_real(meas_real),
        .meas_imag(meas_imag), .meas_temp(meas_temp),
        .meas_req(meas_req), .meas_kind(meas_kind),
        .excite_on(excite_on), .freq_code(freq_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cmd(input logic [3:0] c);
        wr(8'h80, {c, 4'h0});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for a request, answer it, return the wait in cycles.
    task automatic serve(input logic [15:0] re, input logic [15:0] im,
                         input logic [15:0] tp, output int waited,
                         output logic kind);
        waited = 0;
        while (!meas_req && waited < WAIT_LIM) begin
            @(negedge clk);
            waited++;
        end
        kind = meas_kind;
        meas_done = 1'b1; meas_real = re; meas_imag = im; meas_temp = tp;
        @(negedge clk);
        meas_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_freq(input logic [7:0] base, input logic [23:0] v);
        wr(base, v[23:16]); wr(base + 8'd1, v[15:8]); wr(base + 8'd2, v[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        rd(8'h8F, d); check("R1 status", d, 0);
        rd(8'h82, d); check("R1 start byte", d, 0);
        check("R1 freq_code", freq_code, 0);
        check("R1 req/excite", {meas_req, excite_on}, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        set_freq(8'h82, 24'h123456);
        rd(8'h82, d); check("R2 start msb", d, 8'h12);
        rd(8'h84, d); check("R2 start lsb", d, 8'h56);
        set_freq(8'h85, 24'hABCDEF);
        rd(8'h86, d); check("R2 step mid", d, 8'hCD);
        wr(8'h88, 8'hFF); wr(8'h89, 8'hAB);
        rd(8'h88, d); check("R2 count hi 9-bit", d, 8'h01);
        rd(8'h89, d); check("R2 count lo", d, 8'hAB);
        wr(8'h8A, 8'hFF);
        rd(8'h8A, d); check("R2 settle hi 11-bit", d, 8'h07);
        wr(8'h80, 8'h07);
        rd(8'h80, d); check("R13 cfg readback", d, 8'h07);
        idle(5);
        check("R13 code 0 no effect", {meas_req, excite_on, freq_code}, 0);
        wr(8'h81, 8'h08);
        rd(8'h81, d); check("R12 extclk bit", d, 8'h08);
    endtask

    task automatic t_ignored_sweep();
        do_reset();
        cmd(4'h2);
        idle(30);
        check("R4 sweep ignored in standby", {meas_req, freq_code}, 0);
    endtask

    task automatic t_sweep();
        logic [7:0] d; int w; logic k;
        do_reset();
        set_freq(8'h82, 24'h000100);
        set_freq(8'h85, 24'h000010);
        wr(8'h89, 8'd2);
        wr(8'h8B, 8'd3);
        cmd(4'h1);
        check("R3 init code", freq_code, 24'h000100);
        check("R3 excite on", excite_on, 1);
        idle(10);
        check("R3 no request", meas_req, 0);
        cmd(4'h2);
        serve(16'h1234, 16'hFEDC, 16'h0, w, k);
        check("R5 settle latency x1", w, 4);
        check("R4 kind impedance", k, 0);
        rd(8'h94, d); check("R6 real msb", d, 8'h12);
        rd(8'h97, d); check("R6 imag lsb", d, 8'hDC);
        rd(8'h8F, d); check("R6 data valid", d, 8'h02);
        check("R6 request dropped", meas_req, 0);
        cmd(4'h3);
        rd(8'h8F, d); check("R7 valid cleared", d, 8'h00);
        check("R7 code stepped", freq_code, 24'h000110);
        serve(16'h1111, 16'h2222, 16'h0, w, k);
        rd(8'h8F, d); check("R8 not done at step 1", d, 8'h02);
        cmd(4'h4);
        rd(8'h8F, d); check("R9 repeat clears valid", d, 8'h00);
        check("R9 repeat same code", freq_code, 24'h000110);
        serve(16'h3333, 16'h4444, 16'h0, w, k);
        rd(8'h95, d); check("R9 remeasured real", d, 8'h33);
        cmd(4'h3);
        serve(16'h5555, 16'h6666, 16'h0, w, k);
        rd(8'h8F, d); check("R8 done at last step", d, 8'h06);
        cmd(4'h3);
        idle(20);
        check("R7 step ignored after done", {meas_req, freq_code},
              {1'b0, 24'h000120});
        cmd(4'h9);
        serve(16'h0, 16'h0, 16'h1ABC, w, k);
        check("R10 kind temperature", k, 1);
        rd(8'h92, d); check("R10 temp msb", d, 8'h1A);
        rd(8'h8F, d); check("R10 temp valid", d, 8'h07);
        cmd(4'h4);
        idle(10);
        check("R10 returned to hold", meas_req, 1);
        serve(16'h7, 16'h8, 16'h0, w, k);
        cmd(4'hB);
        rd(8'h8F, d); check("R11 standby keeps flags", d, 8'h07);
        check("R11 standby excite off", excite_on, 0);
        cmd(4'h1);
        cmd(4'hA);
        rd(8'h8F, d); check("R11 power down clears", d, 8'h00);
        check("R11 power down excite", excite_on, 0);
    endtask

    task automatic t_settle_mult();
        int w; logic k;
        do_reset();
        wr(8'h8A, 8'h02); wr(8'h8B, 8'h05);
        cmd(4'h1); cmd(4'h2);
        serve(16'h0, 16'h0, 16'h0, w, k);
        check("R5 settle latency x2", w, 11);
        wr(8'h8A, 8'h06);
        cmd(4'h1); cmd(4'h2);
        serve(16'h0, 16'h0, 16'h0, w, k);
        check("R5 settle latency x4", w, 21);
    endtask

    task automatic t_temp_busy();
        int w; logic k;
        do_reset();
        wr(8'h8A, 8'h00); wr(8'h8B, 8'd50);
        cmd(4'h1); cmd(4'h2);
        idle(5);
        cmd(4'h9);
        serve(16'h0, 16'h0, 16'h0, w, k);
        check("R10 temp ignored while settling", k, 0);
    endtask

    task automatic t_wrap();
        int w; logic k;
        do_reset();
        set_freq(8'h82, 24'hFFFFF0);
        set_freq(8'h85, 24'h000020);
        wr(8'h89, 8'd1);
        cmd(4'h1); cmd(4'h2);
        serve(16'h0, 16'h0, 16'h0, w, k);
        cmd(4'h3);
        check("R7 code wraps", freq_code, 24'h000010);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d; int w; logic k;
        do_reset();
        set_freq(8'h82, 24'h00ABCD);
        cmd(4'h1); cmd(4'h2);
        serve(16'h0, 16'h0, 16'h0, w, k);
        wr(8'h81, 8'h18);
        rd(8'h8F, d); check("R12 flags cleared", d, 8'h00);
        check("R12 excite off", excite_on, 0);
        rd(8'h83, d); check("R12 start kept", d, 8'hAB);
        rd(8'h81, d); check("R12 reset bit reads 0", d, 8'h08);
        cmd(4'h2);
        idle(10);
        check("R12 back in standby", meas_req, 0);
    endtask

    task automatic t_long();
        logic [7:0] d; int w; logic k; int early = 0;
        do_reset();
        set_freq(8'h85, 24'h000001);
        wr(8'h88, 8'h01); wr(8'h89, 8'hFF);
        cmd(4'h1); cmd(4'h2);
        serve(16'h0, 16'h0, 16'h0, w, k);
        for (int i = 0; i < 511; i++) begin
            rd(8'h8F, d);
            if (d[2]) early++;
            cmd(4'h3);
            serve(16'h0, 16'h0, 16'h0, w, k);
        end
        check("R8 no early done over 511 steps", early, 0);
        rd(8'h8F, d); check("R8 done at 511", d[2], 1);
        check("R7 code after 511 steps", freq_code, 24'd511);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_ignored_sweep();
        t_sweep();
        t_settle_mult();
        t_temp_busy();
        t_wrap();
        t_soft_reset();
        t_long();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule